// File: doc/BRIEF.md
# Multicast hash address filter

This block sits beside a receive path and decides whether a multicast frame passes the group-address filter. The six destination-address bytes are fed in as a byte stream, opened by a start strobe and qualified by a valid strobe. The block runs the Ethernet CRC-32 over those bytes only, takes six bits of the CRC register as an index, and reads one bit of a 64-bit table. One clock after the sixth byte it produces a one-cycle decision: whether the address was multicast and whether the hash lookup matched.

The table is held in four 16-bit words that are written and read through a small word-select port. When hash filtering is disabled, or when the address is not multicast, the block reports no hash match, which leaves the final decision to other filters. A table write that happens while a frame is in progress is held back from that frame. Its effect starts with the frame that follows.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset all four table words read as zero on `rd_data`, and `dec_vld`, `dec_mcast` and `dec_hit` are low.
- R2: A write with `wr_en` high stores `wr_data` into word `wr_sel`, which holds table bits [16*w+15 : 16*w]. Word 0 holds bit 0 in its LSB and word 3 holds bit 63 in its MSB. Starting the cycle after the write, `rd_data` returns that word when `rd_sel` selects it.
- R3: The CRC register is preset to all ones. Each address bit in turn is folded in as feedback = reg[0] XOR bit, then reg = (reg >> 1) XOR (feedback ? 0xEDB88320 : 0). Bytes are processed in arrival order and the bits of each byte LSB first. The index is reg[5:0] after the sixth byte, with no final complement.
- R4: With `hash_en` high and a multicast address, `dec_hit` equals the table bit selected by the index.
- R5: An address is multicast when bit 0 of its first byte is 1. For a non-multicast address the decision has `dec_mcast` = 0 and `dec_hit` = 0.
- R6: If `hash_en` is low in the cycle of the sixth byte, `dec_hit` is 0 while `dec_mcast` still reports the multicast bit.
- R7: `dec_vld` is high for exactly one cycle, in the cycle after the sixth accepted byte. Bytes that arrive after the sixth and before the next start are ignored and produce no decision.
- R8: `frm_start` presets the CRC and restarts the byte count. The byte presented with `frm_start` is byte 0. A start that comes before six bytes abandons the current frame, and that frame produces no decision.
- R9: A table write made after a frame's start does not change that frame's decision. It does apply to the next frame.
- R10: Bytes with `byte_vld` high that do not follow a start are ignored and produce no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hash_en | input | 1 | Enables hash filtering |
| frm_start | input | 1 | Starts a new address, resetting the CRC and the byte count |
| byte_vld | input | 1 | `byte_data` is valid |
| byte_data | input | 8 | Destination address byte |
| wr_en | input | 1 | Table word write strobe |
| wr_sel | input | 2 | Table word number for the write |
| wr_data | input | 16 | Table word write data |
| rd_sel | input | 2 | Table word number for the read |
| rd_data | output | 16 | Selected table word |
| dec_vld | output | 1 | Decision valid pulse |
| dec_mcast | output | 1 | The address was multicast |
| dec_hit | output | 1 | The hash lookup matched |

## Verification
The bench builds the block with its default parameters: four 16-bit words, a 64-entry table and six address bytes. It feeds several hundred generated multicast addresses. For each one it loads a one-hot table and then its complement, which exercises every index and both polarities against an arithmetic CRC model, with coverage reaching all 64 table positions. Directed frames cover unicast addresses, the disable input, aborted frames, bytes past the sixth, bytes that arrive with no start, and table writes made in the middle of a frame.

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int WORD_W     = 16,
  parameter int TBL_WORDS  = 4,
  parameter int ADDR_BYTES = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          hash_en,
  input  logic                          frm_start,
  input  logic                          byte_vld,
  input  logic [7:0]                    byte_data,
  input  logic                          wr_en,
  input  logic [$clog2(TBL_WORDS)-1:0]  wr_sel,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic [$clog2(TBL_WORDS)-1:0]  rd_sel,
  output logic [WORD_W-1:0]             rd_data,
  output logic                          dec_vld,
  output logic                          dec_mcast,
  output logic                          dec_hit
);
  localparam int TBL_BITS = WORD_W * TBL_WORDS;
  localparam int IDX_W    = $clog2(TBL_BITS);
  localparam int CNT_W    = $clog2(ADDR_BYTES + 1);
  localparam logic [31:0] POLY_REV = 32'hEDB88320;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = {1'b0, r[31:1]} ^ ((r[0] ^ d[i]) ? POLY_REV : 32'h0);
    return r;
  endfunction

  logic [TBL_BITS-1:0] tbl_q, snap_q, tbl_use;
  logic [31:0]         crc_q, crc_in, crc_nx;
  logic [CNT_W-1:0]    cnt_q, cnt_base;
  logic                busy_q, mc_q, mc_now, take, last;

  assign crc_in   = frm_start ? '1 : crc_q;
  assign cnt_base = frm_start ? '0 : cnt_q;
  assign tbl_use  = frm_start ? tbl_q : snap_q;
  assign take     = byte_vld && (frm_start || busy_q);
  assign last     = take && (cnt_base == CNT_W'(ADDR_BYTES - 1));
  assign crc_nx   = crc_byte(crc_in, byte_data);
  assign mc_now   = (cnt_base == '0) ? byte_data[0] : mc_q;
  assign rd_data  = tbl_q[int'(rd_sel) * WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_q <= '0;
    end else if (wr_en) begin
      tbl_q[int'(wr_sel) * WORD_W +: WORD_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q    <= '0;
      crc_q     <= '1;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      mc_q      <= 1'b0;
      dec_vld   <= 1'b0;
      dec_mcast <= 1'b0;
      dec_hit   <= 1'b0;
    end else begin
      snap_q    <= tbl_use;
      crc_q     <= take ? crc_nx : crc_in;
      cnt_q     <= take ? cnt_base + CNT_W'(1) : cnt_base;
      mc_q      <= take ? mc_now : mc_q;
      busy_q    <= (frm_start || busy_q) && !last;
      dec_vld   <= last;
      dec_mcast <= last && mc_now;
      dec_hit   <= last && mc_now && hash_en && tbl_use[crc_nx[IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
  parameter int WORD_W    = 16,
  parameter int TBL_WORDS = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          hash_en,
  input logic                          byte_vld,
  input logic                          wr_en,
  input logic [$clog2(TBL_WORDS)-1:0]  wr_sel,
  input logic [WORD_W-1:0]             wr_data,
  input logic [$clog2(TBL_WORDS)-1:0]  rd_sel,
  input logic [WORD_W-1:0]             rd_data,
  input logic                          dec_vld,
  input logic                          dec_mcast,
  input logic                          dec_hit
);
  a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && rd_sel == $past(wr_sel)) |-> rd_data == $past(wr_data));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |=> !dec_vld);

  a_r7_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> $past(byte_vld));

  a_r6_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> ($past(hash_en) && dec_vld));

  a_r5_hit_needs_mcast: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> dec_mcast);

  a_r5_mcast_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
    dec_mcast |-> dec_vld);
endmodule

bind mcast_hash_filter mhf_checker #(.WORD_W(WORD_W), .TBL_WORDS(TBL_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hash_en(hash_en), .byte_vld(byte_vld),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
  .rd_data(rd_data), .dec_vld(dec_vld), .dec_mcast(dec_mcast), .dec_hit(dec_hit)
);

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;
  logic clk = 1'b0, rst_n = 1'b0, hash_en = 1'b0, frm_start = 1'b0, byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0, rd_sel = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic        dec_vld, dec_mcast, dec_hit;
  int vectors = 0, fails = 0, cyc = 0;
  logic [31:0] lcg = 32'h1234_5678;
  logic [63:0] covered = '0;

  always #5 clk = ~clk;

  mcast_hash_filter dut (.*);

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      report();
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = '1;
    for (int k = 0; k < 48; k++) begin
      logic fb = c[0] ^ a[k];
      c = (c >> 1) ^ (fb ? 32'hEDB88320 : 32'h0);
    end
    return c[5:0];
  endfunction

  task automatic wr_word(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_table(input logic [63:0] t);
    for (int w = 0; w < 4; w++) wr_word(2'(w), t[16*w +: 16]);
  endtask

  task automatic run_frame(input logic [47:0] a, input logic mid_wr, input logic [1:0] ws,
                           input logic [15:0] wd, output logic v, output logic m, output logic h);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      frm_start = (k == 0); byte_vld = 1'b1; byte_data = a[8*k +: 8];
      wr_en = mid_wr && (k == 2); wr_sel = ws; wr_data = wd;
    end
    @(negedge clk);
    frm_start = 1'b0; byte_vld = 1'b0; wr_en = 1'b0;
    v = dec_vld; m = dec_mcast; h = dec_hit;
  endtask

  initial begin
    logic v, m, h;
    logic [47:0] a;
    logic [5:0] ix;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int w = 0; w < 4; w++) begin
      rd_sel = 2'(w); #1;
      check("R1 table word reset", rd_data, 0);
    end
    check("R1 decision reset", {dec_vld, dec_mcast, dec_hit}, 0);

    for (int w = 0; w < 4; w++) wr_word(2'(w), 16'hA5C0 ^ 16'(w * 16'h1111));
    for (int w = 0; w < 4; w++) begin
      rd_sel = 2'(w); #1;
      check("R2 word readback", rd_data, 16'hA5C0 ^ 16'(w * 16'h1111));
    end

    for (int k = 0; k < 8; k++) begin
      @(negedge clk); byte_vld = 1'b1; byte_data = 8'hFF;
      @(negedge clk); byte_vld = 1'b0;
      check("R10 bytes without start", dec_vld, 0);
    end

    hash_en = 1'b1;
    for (int n = 0; n < 400; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a = {lcg, lcg[31:16] ^ 16'(n)};
      a[0] = 1'b1;
      ix = ref_idx(a);
      covered[ix] = 1'b1;
      set_table(64'd1 << ix);
      run_frame(a, 1'b0, 2'd0, 16'd0, v, m, h);
      check("R3 R4 one-hot index hit", {v, m, h}, 3'b111);
      set_table(~(64'd1 << ix));
      run_frame(a, 1'b0, 2'd0, 16'd0, v, m, h);
      check("R3 R4 complement index miss", {v, m, h}, 3'b110);
    end
    check("R3 all 64 indices covered", covered, 64'hFFFF_FFFF_FFFF_FFFF);

    set_table('1);
    run_frame(48'h0000_5E00_0A02, 1'b0, 2'd0, 16'd0, v, m, h);
    check("R5 unicast no match", {v, m, h}, 3'b100);

    hash_en = 1'b0;
    run_frame(48'h0000_5E00_0A01, 1'b0, 2'd0, 16'd0, v, m, h);
    check("R6 disabled no match", {v, m, h}, 3'b110);
    hash_en = 1'b1;

    a = 48'h3344_5566_7701;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); byte_vld = 1'b1; byte_data = 8'h5A;
      @(negedge clk); byte_vld = 1'b0;
      check("R7 extra bytes ignored", dec_vld, 0);
    end

    ix = ref_idx(a);
    set_table(64'd1 << ix);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); frm_start = (k == 0); byte_vld = 1'b1; byte_data = 8'hC3;
    end
    @(negedge clk); frm_start = 1'b0; byte_vld = 1'b0;
    check("R8 aborted partial no decision", dec_vld, 0);
    run_frame(a, 1'b0, 2'd0, 16'd0, v, m, h);
    check("R8 restart after abort", {v, m, h}, 3'b111);
    @(negedge clk);
    check("R7 pulse one cycle", dec_vld, 0);

    set_table('0);
    run_frame(a, 1'b1, 2'(ix / 16), 16'hFFFF, v, m, h);
    check("R9 mid-frame write held back", {v, m, h}, 3'b110);
    run_frame(a, 1'b0, 2'd0, 16'd0, v, m, h);
    check("R9 write applies next frame", {v, m, h}, 3'b111);

    report();
  end
endmodule